// File: doc/BRIEF.md
# I2C Write-Only Potentiometer Control Slave

This block is the serial front end of a controller for two 256-position digital potentiometers. It receives write frames on a two-wire I2C bus and turns each complete frame into one update of a small register file. The register file holds two live wiper positions and two nonvolatile copies. The nonvolatile copies are modelled here as plain registers. The block oversamples SCL and SDA on its own system clock, so the system clock must run at least eight times faster than SCL. It never drives SCL. On SDA it only pulls the line low, through an open-drain enable.

A frame has a fixed shape. It starts with a START condition. Next comes an address byte: a fixed `0101` prefix, then three strap-pin levels, then a write/no-operation bit. A command byte and a data byte follow, and the frame ends with a STOP. The command byte selects a channel and an action. The action can write the wiper, store the wiper, recall the wiper, or write both the wiper and its stored copy. The register file is changed only after the data byte has been acknowledged. While the write-protect input is high, any change to a stored copy is blocked. Changes to the wipers still go through.

Top module: `potctl_i2c_slave`

## Requirements
- R1: The slave acknowledges an address byte whose upper seven bits equal `0101` followed by `addr_pins_i[2]`, `addr_pins_i[1]`, `addr_pins_i[0]` (MSB first on the bus) and whose eighth bit is 0 (write).
- R2: If the address does not match, or the eighth bit is 1 (no-operation), the slave acknowledges nothing. It ignores all bus traffic until the next START, and no output register changes.
- R3: START (SDA falls while SCL is high) begins a new frame from any state. A STOP (SDA rises while SCL is high) or a repeated START that arrives before the data byte has been acknowledged discards the frame, and no register changes.
- R4: The acknowledge is an open-drain pull. `sda_pull_o` rises on the SCL falling edge that ends the eighth bit of an accepted byte. It stays high through the whole ninth clock and is released on the falling edge that ends that clock.
- R5: Bytes are taken MSB first, sampled while SCL is high. The command and data are applied as one single-cycle update, and only on the SCL falling edge that ends the acknowledge of the data byte.
- R6: Command bits [2:1] = 00 write the data byte to the selected wiper.
- R7: Command bits [2:1] = 01 copy the selected wiper into its stored copy.
- R8: Command bits [2:1] = 10 load the selected wiper from its stored copy. This is allowed whatever the write-protect level.
- R9: Command bits [2:1] = 11 write the data byte to both the selected wiper and its stored copy.
- R10: Command bit 0 selects the channel: 0 selects channel A and 1 selects channel B. The other channel is left unchanged.
- R11: While `wp_i` is high, no stored copy changes. The wiper part of a command still takes effect.
- R12: A command with any of bits [7:3] set is still acknowledged in full, but it has no effect on any register.
- R13: After reset, both wipers and both stored copies read 0x80, and `sda_pull_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| addr_pins_i | input | 3 | Strap levels forming the low address bits |
| wp_i | input | 1 | Write protect for the stored copies, active high |
| sda_pull_o | output | 1 | Open-drain enable; 1 pulls SDA low |
| wiper_a_o | output | 8 | Channel A wiper position |
| wiper_b_o | output | 8 | Channel B wiper position |
| nv_a_o | output | 8 | Channel A stored copy |
| nv_b_o | output | 8 | Channel B stored copy |

## Verification
Directed frames drive each of the four actions on each channel, with protect both low and high. This separates the wiper path from the stored-copy path, and it shows that the channel-select bit reaches only its own channel. Further directed frames use a wrong address prefix, the no-operation bit, an unknown command, a STOP after the command byte and a repeated START inside the data byte. These show the difference between refusing a frame, acknowledging it without acting, and discarding a partial frame. Randomized frames then mix strap values, protect levels, commands, data and these fault shapes, so that the sequence of stored and recalled values builds up over many frames. A bench model checks the acknowledge on every byte and all four registers after every frame.

// File: rtl/potctl_pkg.sv
package potctl_pkg;

  localparam int BYTE_W = 8;

  // Action carried in the command byte just above the channel select
  typedef enum logic [1:0] {
    ACT_WRITE  = 2'b00,
    ACT_STORE  = 2'b01,
    ACT_RECALL = 2'b10,
    ACT_BOTH   = 2'b11
  } act_e;

  // Receiver frame position
  typedef enum logic [2:0] {
    FR_IDLE,
    FR_ADDR,
    FR_ADDR_ACK,
    FR_CMD,
    FR_CMD_ACK,
    FR_DATA,
    FR_DATA_ACK,
    FR_SKIP
  } frame_e;

endpackage

// File: rtl/i2c_line_sync.sv
// Synchronizes both bus lines and derives clock edges and bus conditions.
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_q;
  logic              sda_q;
  logic              scl_s;

  // Idle bus reads high, so reset to ones
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign bus_start = scl_s & scl_q & sda_q & ~sda_s;
  assign bus_stop  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_frame_rx.sv
// Frame receiver: address match, command and data bytes, acknowledge drive.
module i2c_frame_rx
  import potctl_pkg::*;
#(
  parameter int                        ADDR_W = 7,
  parameter int                        PIN_W  = 3,
  parameter logic [ADDR_W-PIN_W-1:0]   PREFIX = 4'b0101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic [PIN_W-1:0]  addr_pins,
  output logic              sda_pull,
  output logic              apply_stb,
  output logic [BYTE_W-1:0] cmd_byte,
  output logic [BYTE_W-1:0] data_byte
);

  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  frame_e            state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] shift_q, shift_d;
  logic [BYTE_W-1:0] cmd_q, cmd_d;
  logic [BYTE_W-1:0] data_q, data_d;
  logic              pull_q, pull_d;
  logic              stb_q, stb_d;
  logic              addr_hit;
  logic              in_byte;

  assign addr_hit = (shift_q[BYTE_W-1:1] == {PREFIX, addr_pins}) && !shift_q[0];
  assign in_byte  = (state_q == FR_ADDR) || (state_q == FR_CMD) || (state_q == FR_DATA);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    shift_d = shift_q;
    cmd_d   = cmd_q;
    data_d  = data_q;
    pull_d  = pull_q;
    stb_d   = 1'b0;
    if (bus_start) begin
      state_d = FR_ADDR;
      cnt_d   = '0;
      pull_d  = 1'b0;
    end else if (bus_stop) begin
      state_d = FR_IDLE;
      cnt_d   = '0;
      pull_d  = 1'b0;
    end else if (in_byte) begin
      if (scl_rise && (cnt_q != FULL)) begin
        shift_d = {shift_q[BYTE_W-2:0], sda_s};
        cnt_d   = cnt_q + 1'b1;
      end else if (scl_fall && (cnt_q == FULL)) begin
        cnt_d = '0;
        unique case (state_q)
          FR_ADDR: begin
            state_d = addr_hit ? FR_ADDR_ACK : FR_SKIP;
            pull_d  = addr_hit;
          end
          FR_CMD: begin
            cmd_d   = shift_q;
            state_d = FR_CMD_ACK;
            pull_d  = 1'b1;
          end
          default: begin
            data_d  = shift_q;
            state_d = FR_DATA_ACK;
            pull_d  = 1'b1;
          end
        endcase
      end
    end else if (scl_fall) begin
      unique case (state_q)
        FR_ADDR_ACK: begin
          state_d = FR_CMD;
          pull_d  = 1'b0;
        end
        FR_CMD_ACK: begin
          state_d = FR_DATA;
          pull_d  = 1'b0;
        end
        FR_DATA_ACK: begin
          state_d = FR_SKIP;
          pull_d  = 1'b0;
          stb_d   = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FR_IDLE;
      cnt_q   <= '0;
      shift_q <= '0;
      cmd_q   <= '0;
      data_q  <= '0;
      pull_q  <= 1'b0;
      stb_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      shift_q <= shift_d;
      cmd_q   <= cmd_d;
      data_q  <= data_d;
      pull_q  <= pull_d;
      stb_q   <= stb_d;
    end
  end

  assign sda_pull  = pull_q;
  assign apply_stb = stb_q;
  assign cmd_byte  = cmd_q;
  assign data_byte = data_q;

endmodule

// File: rtl/wiper_regfile.sv
// Wiper positions and their protected stored copies.
module wiper_regfile
  import potctl_pkg::*;
#(
  parameter int              NCH   = 2,
  parameter int              W     = 8,
  parameter logic [W-1:0]    RST_V = 8'h80
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  apply_stb,
  input  logic [BYTE_W-1:0]     cmd,
  input  logic [W-1:0]          data,
  input  logic                  wp,
  output logic [NCH-1:0][W-1:0] wiper,
  output logic [NCH-1:0][W-1:0] nv
);

  localparam int SEL_W = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int ACT_L = SEL_W;

  logic [SEL_W-1:0] sel;
  act_e             act;
  logic             known;

  assign sel   = cmd[SEL_W-1:0];
  assign act   = act_e'(cmd[ACT_L+1:ACT_L]);
  assign known = (cmd[BYTE_W-1:ACT_L+2] == '0);

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic         hit;
    logic         wip_en, nv_en;
    logic [W-1:0] wip_nxt, nv_nxt;
    logic [W-1:0] wip_q, nv_q;

    always_comb begin
      hit     = apply_stb && known && (sel == SEL_W'(ch));
      wip_en  = hit && (act != ACT_STORE);
      wip_nxt = (act == ACT_RECALL) ? nv_q : data;
      nv_en   = hit && !wp && ((act == ACT_STORE) || (act == ACT_BOTH));
      nv_nxt  = (act == ACT_STORE) ? wip_q : data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wip_q <= RST_V;
        nv_q  <= RST_V;
      end else begin
        if (wip_en) wip_q <= wip_nxt;
        if (nv_en)  nv_q  <= nv_nxt;
      end
    end

    assign wiper[ch] = wip_q;
    assign nv[ch]    = nv_q;
  end

endmodule

// File: rtl/potctl_i2c_slave.sv
// Top: reset conditioning, line synchronizer, frame receiver, register file.
module potctl_i2c_slave
  import potctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PIN_W       = 3,
  parameter int W           = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_in,
  input  logic             sda_in,
  input  logic [PIN_W-1:0] addr_pins_i,
  input  logic             wp_i,
  output logic             sda_pull_o,
  output logic [W-1:0]     wiper_a_o,
  output logic [W-1:0]     wiper_b_o,
  output logic [W-1:0]     nv_a_o,
  output logic [W-1:0]     nv_b_o
);

  localparam int NCH = 2;

  logic [1:0]               rst_pipe;
  logic                     rst_ns;
  logic                     sda_s, scl_rise, scl_fall, bus_start, bus_stop;
  logic                     apply_stb;
  logic [BYTE_W-1:0]        cmd_byte, data_byte;
  logic [NCH-1:0][W-1:0]    wiper, nv;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ns = rst_pipe[1];

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_ns),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .bus_start (bus_start),
    .bus_stop  (bus_stop)
  );

  i2c_frame_rx #(.ADDR_W(7), .PIN_W(PIN_W), .PREFIX(4'b0101)) u_rx (
    .clk       (clk),
    .rst_n     (rst_ns),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .bus_start (bus_start),
    .bus_stop  (bus_stop),
    .addr_pins (addr_pins_i),
    .sda_pull  (sda_pull_o),
    .apply_stb (apply_stb),
    .cmd_byte  (cmd_byte),
    .data_byte (data_byte)
  );

  wiper_regfile #(.NCH(NCH), .W(W), .RST_V(W'(8'h80))) u_regs (
    .clk       (clk),
    .rst_n     (rst_ns),
    .apply_stb (apply_stb),
    .cmd       (cmd_byte),
    .data      (data_byte),
    .wp        (wp_i),
    .wiper     (wiper),
    .nv        (nv)
  );

  assign wiper_a_o = wiper[0];
  assign wiper_b_o = wiper[1];
  assign nv_a_o    = nv[0];
  assign nv_b_o    = nv[1];

endmodule

// File: rtl/potctl_i2c_slave_chk.sv
module potctl_i2c_slave_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_ns,
  input logic         wp_i,
  input logic         sda_pull_o,
  input logic         apply_stb,
  input logic         scl_fall,
  input logic         bus_start,
  input logic         bus_stop,
  input logic [W-1:0] wiper_a_o,
  input logic [W-1:0] wiper_b_o,
  input logic [W-1:0] nv_a_o,
  input logic [W-1:0] nv_b_o
);

  // R4: the acknowledge pull starts only on a synchronized SCL falling edge
  assert_pull_rise_R4: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(sda_pull_o) |-> $past(scl_fall));

  // R4 / R3: the pull is released on a falling edge or a bus condition
  assert_pull_fall_R4: assert property (@(posedge clk) disable iff (!rst_ns)
    $fell(sda_pull_o) |-> $past(scl_fall || bus_start || bus_stop));

  // R5: the update strobe lasts one cycle
  assert_stb_single_R5: assert property (@(posedge clk) disable iff (!rst_ns)
    apply_stb |=> !apply_stb);

  // R5: wipers move only right after the update strobe
  assert_wiper_hold_R5: assert property (@(posedge clk) disable iff (!rst_ns)
    !$past(apply_stb) |-> ($stable(wiper_a_o) && $stable(wiper_b_o)));

  // R7: stored copies move only right after the update strobe
  assert_nv_hold_R7: assert property (@(posedge clk) disable iff (!rst_ns)
    !$past(apply_stb) |-> ($stable(nv_a_o) && $stable(nv_b_o)));

  // R11: protect high freezes the stored copies
  assert_nv_wp_R11: assert property (@(posedge clk) disable iff (!rst_ns)
    $past(wp_i) |-> ($stable(nv_a_o) && $stable(nv_b_o)));

endmodule

bind potctl_i2c_slave potctl_i2c_slave_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_ns     (rst_ns),
  .wp_i       (wp_i),
  .sda_pull_o (sda_pull_o),
  .apply_stb  (apply_stb),
  .scl_fall   (scl_fall),
  .bus_start  (bus_start),
  .bus_stop   (bus_stop),
  .wiper_a_o  (wiper_a_o),
  .wiper_b_o  (wiper_b_o),
  .nv_a_o     (nv_a_o),
  .nv_b_o     (nv_b_o)
);

// File: tb/potctl_i2c_slave_test.sv
module potctl_i2c_slave_test;

  localparam int CLK_PERIOD = 10;
  localparam int Q          = 4;   // SCL quarter period in system clocks

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic [2:0] pins = 3'd0;
  logic       wp = 1'b0;
  logic       sda_pull;
  logic       sda_bus;
  logic [7:0] wa, wb, na, nb;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0] mw [2];
  logic [7:0] mn [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sda_bus = sda_m & ~sda_pull;

  potctl_i2c_slave uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_in      (scl_m),
    .sda_in      (sda_bus),
    .addr_pins_i (pins),
    .wp_i        (wp),
    .sda_pull_o  (sda_pull),
    .wiper_a_o   (wa),
    .wiper_b_o   (wb),
    .nv_a_o      (na),
    .nv_b_o      (nb)
  );

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Expected register effect of one accepted frame
  task automatic model_apply(input logic [7:0] cmd, input logic [7:0] data, input logic prot);
    int s;
    if (cmd[7:3] != 5'd0) return;
    s = int'(cmd[0]);
    case (cmd[2:1])
      2'b00: mw[s] = data;
      2'b01: if (!prot) mn[s] = mw[s];
      2'b10: mw[s] = mn[s];
      default: begin
        mw[s] = data;
        if (!prot) mn[s] = data;
      end
    endcase
  endtask

  function automatic bit exp_hit(input logic [6:0] addr, input logic rw, input logic [2:0] p);
    return (addr == {4'b0101, p}) && !rw;
  endfunction

  task automatic bus_start_cond();
    sda_m = 1'b1; wait_clks(Q);
    scl_m = 1'b1; wait_clks(Q);
    sda_m = 1'b0; wait_clks(Q);
    scl_m = 1'b0; wait_clks(Q);
  endtask

  task automatic bus_stop_cond();
    sda_m = 1'b0; wait_clks(Q);
    scl_m = 1'b1; wait_clks(Q);
    sda_m = 1'b1; wait_clks(2*Q);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b;    wait_clks(Q);
    scl_m = 1'b1; wait_clks(2*Q);
    scl_m = 1'b0; wait_clks(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; wait_clks(Q);
    scl_m = 1'b1; wait_clks(Q);
    acked = (sda_bus == 1'b0);
    wait_clks(Q);
    scl_m = 1'b0; wait_clks(Q);
  endtask

  task automatic compare_regs(input string tag);
    check(wa == mw[0], {tag, " wiper A"}, 32'(wa), 32'(mw[0]));
    check(wb == mw[1], {tag, " wiper B"}, 32'(wb), 32'(mw[1]));
    check(na == mn[0], {tag, " stored A"}, 32'(na), 32'(mn[0]));
    check(nb == mn[1], {tag, " stored B"}, 32'(nb), 32'(mn[1]));
    check(sda_pull == 1'b0, {tag, " R4 pull released"}, 32'(sda_pull), 32'd0);
  endtask

  // abort: 0 full frame, 1 STOP after command (R3), 2 repeated START in data (R3)
  task automatic run_frame(input logic [6:0] addr, input logic rw, input logic [7:0] cmd,
                           input logic [7:0] data, input int abort, input string tag);
    bit a;
    bit hit;
    hit = exp_hit(addr, rw, pins);
    bus_start_cond();
    send_byte({addr, rw}, a);
    check(a == hit, {tag, " R1 R2 address ack"}, 32'(a), 32'(hit));
    send_byte(cmd, a);
    check(a == hit, {tag, " R2 R12 command ack"}, 32'(a), 32'(hit));
    if (abort == 1) begin
      bus_stop_cond();
    end else if (abort == 2) begin
      for (int i = 7; i >= 4; i--) send_bit(data[i]);
      bus_start_cond();
      bus_stop_cond();
    end else begin
      send_byte(data, a);
      check(a == hit, {tag, " R5 data ack"}, 32'(a), 32'(hit));
      bus_stop_cond();
      if (hit) model_apply(cmd, data, wp);
    end
    wait_clks(6);
    compare_regs(tag);
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual %0d expected %0d", 150000, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [6:0] ad;
    logic       rw;
    logic [7:0] cmd, dat;
    int         kind;
    void'($urandom(32'h5eed_0c1a));
    mw[0] = 8'h80; mw[1] = 8'h80; mn[0] = 8'h80; mn[1] = 8'h80;
    wait_clks(4);
    rst_n = 1'b1;
    wait_clks(6);

    // R13 reset state
    compare_regs("R13 reset");

    // R6 R10 write each wiper, protect low
    pins = 3'b101; wp = 1'b0; wait_clks(4);
    run_frame({4'b0101, 3'b101}, 1'b0, 8'h00, 8'h3c, 0, "R6 R10 write A");
    run_frame({4'b0101, 3'b101}, 1'b0, 8'h01, 8'hc5, 0, "R6 R10 write B");
    // R7 store, R8 recall
    run_frame({4'b0101, 3'b101}, 1'b0, 8'h02, 8'h00, 0, "R7 store A");
    run_frame({4'b0101, 3'b101}, 1'b0, 8'h00, 8'h11, 0, "R6 rewrite A");
    run_frame({4'b0101, 3'b101}, 1'b0, 8'h04, 8'hff, 0, "R8 recall A");
    // R9 both on B
    run_frame({4'b0101, 3'b101}, 1'b0, 8'h07, 8'h5a, 0, "R9 both B");
    // R11 protect: store and both blocked, recall and write still work
    wp = 1'b1; wait_clks(4);
    run_frame({4'b0101, 3'b101}, 1'b0, 8'h06, 8'h99, 0, "R11 both A protected");
    run_frame({4'b0101, 3'b101}, 1'b0, 8'h03, 8'h00, 0, "R11 store B protected");
    run_frame({4'b0101, 3'b101}, 1'b0, 8'h04, 8'h00, 0, "R11 R8 recall A protected");
    wp = 1'b0; wait_clks(4);
    // R12 unknown command
    run_frame({4'b0101, 3'b101}, 1'b0, 8'h08, 8'h21, 0, "R12 unknown");
    run_frame({4'b0101, 3'b101}, 1'b0, 8'hf0, 8'h22, 0, "R12 unknown high");
    // R2 wrong address and no-operation bit
    run_frame({4'b0101, 3'b100}, 1'b0, 8'h00, 8'h77, 0, "R2 wrong pins");
    run_frame({4'b0111, 3'b101}, 1'b0, 8'h00, 8'h77, 0, "R2 wrong prefix");
    run_frame({4'b0101, 3'b101}, 1'b1, 8'h00, 8'h77, 0, "R2 nop bit");
    // R3 aborts
    run_frame({4'b0101, 3'b101}, 1'b0, 8'h00, 8'h44, 1, "R3 stop after command");
    run_frame({4'b0101, 3'b101}, 1'b0, 8'h01, 8'h44, 2, "R3 repeated start");
    // R1 boundary strap values
    pins = 3'b000; wait_clks(4);
    run_frame({4'b0101, 3'b000}, 1'b0, 8'h00, 8'h01, 0, "R1 pins 000");
    pins = 3'b111; wait_clks(4);
    run_frame({4'b0101, 3'b111}, 1'b0, 8'h01, 8'hfe, 0, "R1 pins 111");

    // Random mix
    for (int n = 0; n < 60; n++) begin
      pins = 3'($urandom % 8);
      wp   = 1'($urandom % 2);
      wait_clks(4);
      kind = int'($urandom % 10);
      ad   = {4'b0101, pins};
      rw   = 1'b0;
      cmd  = 8'($urandom % 8);
      if ($urandom % 8 == 0) cmd = cmd | 8'h10;
      dat  = 8'($urandom);
      if (kind == 0) ad = {4'b0101, pins ^ 3'($urandom % 7 + 1)};
      if (kind == 1) rw = 1'b1;
      run_frame(ad, rw, cmd, dat, (kind == 2) ? 1 : (kind == 3) ? 2 : 0, "R5 random");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule